// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two wires of a low-speed USB link into stored packet bytes. It runs from a system clock that is sixteen times faster than... more precisely, a clock that gives a nominal bit period of 10 2/3 cycles. It first passes both line inputs through a two-flop synchronizer. It then locks onto the sync field and samples every following bit near its centre. Each sampled bit is NRZI-decoded, stuffed bits are removed, and bytes are built least significant bit first. Each finished byte is presented to a byte buffer as a one-cycle write strobe, with its data and a buffer index.

The end of a packet is a single-ended zero seen at a sample point. The block then pulses an end-of-packet flag together with the number of bytes stored. There are two error outcomes. A packet longer than the buffer is dropped with an overflow pulse. A sync attempt that never confirms gives a no-sync pulse. The block does not check CRCs, does not interpret packet identifiers and does not transmit. A buffer-ready input lets the consumer hold the receiver off while it is still processing the previous packet.

Top module: `lsusb_rx`

## Requirements
- R1: After reset, `wr_en`, `eop_valid`, `err_overflow` and `err_nosync` are all low.
- R2: The line states are decoded as follows, with `{dp_in, dm_in}` shown as two bits:
  - J is `01`; it is also the idle state.
  - K is `10`.
  - SE0 is `00`.
  
  A packet is accepted only after a J-to-K edge that is followed, 16 clocks later, by a K sample. This means the sync field must end in two K bits. A sync field whose last bit is J produces no byte write and no end-of-packet.
- R3: A bit whose line level equals the previous bit's level decodes as 1; a change decodes as 0. Bits fill each byte from bit 0 upward. Each completed byte gives one `wr_en` pulse with `wr_data`. `wr_addr` is 0 for the first byte of a packet and goes up by one for each later byte. Two writes are never on consecutive cycles.
- R4: After six decoded 1 bits in a row, the next bit is dropped and does not enter any byte. The run counter restarts on every decoded 0 and at the start of each packet.
- R5: Sample points are spaced 10 or 11 clocks apart. Three consecutive bit periods always total 32 clocks, so every 24 bits take exactly 256 clocks. As a result, a packet that fills the whole buffer at the nominal rate is received without error.
- R6: An SE0 sample ends the packet. `eop_valid` then pulses for one cycle, and `eop_len` gives the number of bytes written. A packet with no data bytes reports length 0.
- R7: If a packet has more bytes than the buffer holds (BUF_BYTES, default 8), the following happens:
  - no write is made for the extra byte;
  - `err_overflow` pulses once;
  - no `eop_valid` is given for that packet;
  - the receiver accepts the next packet once it has seen an SE0.
- R8: A failed sync confirmation opens a search window of 24 clocks. If no K appears within that window, `err_nosync` pulses once and nothing is written.
- R9: While `buf_ready` is low and no packet is in progress, line activity is ignored. No write, end-of-packet or error pulse is given.
- R10: At most one of `wr_en`, `eop_valid`, `err_overflow` and `err_nosync` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominal 10 2/3 cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | D+ line, asynchronous |
| dm_in | input | 1 | D- line, asynchronous |
| buf_ready | input | 1 | High when the consumer can accept a new packet |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | $clog2(BUF_BYTES) | Buffer index of the byte being written |
| wr_data | output | 8 | Received byte |
| eop_valid | output | 1 | One-cycle end-of-packet pulse |
| eop_len | output | $clog2(BUF_BYTES+1) | Bytes stored in the packet just ended |
| err_overflow | output | 1 | One-cycle pulse when a packet exceeds the buffer |
| err_nosync | output | 1 | One-cycle pulse when sync acquisition is abandoned |

## Verification
The hardest case to reach from the ports is sync rejection followed by re-acquisition. Here the receiver locks onto an early K of the sync field, finds J at the confirm point, and has to find the next K inside its window. Normal packets reach this path three times per sync field, because the host model plays every bit with the exact 10/11/11 spacing that any real sender would have. A separate sync field ending in J forces the window to expire. A lone K glitch exercises the same timeout from the first edge. Long packets of stuffed all-ones bytes, and a packet that fills the buffer, stress the fractional bit timing at its furthest point from the sync field.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_CONFIRM = 3'd2,
    ST_HUNT    = 3'd3,
    ST_RECV    = 3'd4,
    ST_DRAIN   = 3'd5
  } rx_state_t;

  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE0 = 2'b00;

endpackage

// File: rtl/lsrx_sync2.sv
module lsrx_sync2 #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[g]}};
      else        ff_q <= {ff_q[STAGES-2:0], din[g]};
    end

    assign dout[g] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/lsrx_bit_timer.sv
module lsrx_bit_timer #(
  parameter int INT_CLKS = 10,
  parameter int FRAC_NUM = 2,
  parameter int FRAC_DEN = 3,
  parameter int CW       = 5,
  localparam int AW      = (FRAC_DEN > 1) ? $clog2(FRAC_DEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [AW-1:0] load_acc,
  input  logic          run,
  output logic          tick
);

  localparam int SW = AW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [SW-1:0] acc_sum;
  logic          carry;

  // fractional phase: every tick adds FRAC_NUM/FRAC_DEN of a clock
  always_comb begin
    acc_sum = {1'b0, acc_q} + SW'(FRAC_NUM);
    carry   = (acc_sum >= SW'(FRAC_DEN));
    tick    = run && (cnt_q == CW'(1));
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    if (load) begin
      cnt_d = load_val;
      acc_d = load_acc;
    end else if (tick) begin
      cnt_d = CW'(INT_CLKS) + CW'(carry);
      acc_d = carry ? AW'(acc_sum - SW'(FRAC_DEN)) : AW'(acc_sum);
    end else if (run) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(INT_CLKS);
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/lsrx_nrzi_unstuff.sv
module lsrx_nrzi_unstuff #(
  parameter int STUFF_RUN = 6,
  localparam int OW       = $clog2(STUFF_RUN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic       level,
  output logic       byte_done,
  output logic [7:0] byte_val
);

  logic          prev_q, prev_d;
  logic [OW-1:0] ones_q, ones_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [2:0]    bidx_q, bidx_d;
  logic          bit_one;
  logic          is_stuff;

  always_comb begin
    bit_one   = (level == prev_q);
    is_stuff  = (ones_q == OW'(STUFF_RUN));
    byte_val  = {bit_one, shreg_q[7:1]};
    byte_done = step && !is_stuff && (bidx_q == 3'd7);

    prev_d  = prev_q;
    ones_d  = ones_q;
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    if (clear) begin
      prev_d  = 1'b0;           // last sync bit is K: D- low
      ones_d  = '0;
      shreg_d = '0;
      bidx_d  = '0;
    end else if (step) begin
      prev_d = level;
      if (is_stuff) begin
        ones_d = '0;
      end else begin
        shreg_d = byte_val;
        bidx_d  = bidx_q + 3'd1;
        ones_d  = bit_one ? ones_q + OW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      ones_q  <= '0;
      shreg_q <= '0;
      bidx_q  <= '0;
    end else begin
      prev_q  <= prev_d;
      ones_q  <= ones_d;
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
    end
  end

endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsrx_pkg::*;
#(
  parameter int BUF_BYTES    = 8,
  parameter int INT_CLKS     = 10,
  parameter int FRAC_NUM     = 2,
  parameter int FRAC_DEN     = 3,
  parameter int CONFIRM_CLKS = 16,
  parameter int SYNC_WINDOW  = 24,
  parameter int STUFF_RUN    = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dp_in,
  input  logic                           dm_in,
  input  logic                           buf_ready,
  output logic                           wr_en,
  output logic [$clog2(BUF_BYTES)-1:0]   wr_addr,
  output logic [7:0]                     wr_data,
  output logic                           eop_valid,
  output logic [$clog2(BUF_BYTES+1)-1:0] eop_len,
  output logic                           err_overflow,
  output logic                           err_nosync
);

  localparam int AW    = $clog2(BUF_BYTES);
  localparam int LW    = $clog2(BUF_BYTES + 1);
  localparam int TMAX0 = (CONFIRM_CLKS > SYNC_WINDOW) ? CONFIRM_CLKS : SYNC_WINDOW;
  localparam int TMAX  = (TMAX0 > INT_CLKS + 1) ? TMAX0 : INT_CLKS + 1;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int FW    = (FRAC_DEN > 1) ? $clog2(FRAC_DEN) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line synchronizer, reset to J
  logic [1:0] line_s;

  lsrx_sync2 #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_J)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({dp_in, dm_in}),
    .dout (line_s)
  );

  logic ln_j, ln_k, ln_se0;
  assign ln_j   = (line_s == LINE_J);
  assign ln_k   = (line_s == LINE_K);
  assign ln_se0 = (line_s == LINE_SE0);

  // bit timer
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_run;
  logic          tick;

  lsrx_bit_timer #(
    .INT_CLKS(INT_CLKS),
    .FRAC_NUM(FRAC_NUM),
    .FRAC_DEN(FRAC_DEN),
    .CW      (CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .load_acc(FW'(1)),
    .run     (tmr_run),
    .tick    (tick)
  );

  // decoder
  logic       dec_clear;
  logic       dec_step;
  logic       byte_done;
  logic [7:0] byte_val;

  lsrx_nrzi_unstuff #(
    .STUFF_RUN(STUFF_RUN)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (dec_clear),
    .step     (dec_step),
    .level    (line_s[0]),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  // control state and outputs
  rx_state_t     state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          wr_en_q, wr_en_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]    wr_data_q, wr_data_d;
  logic          eop_q, eop_d;
  logic [LW-1:0] len_q, len_d;
  logic          ovf_q, ovf_d;
  logic          nos_q, nos_d;

  assign tmr_run = (state_q == ST_CONFIRM) || (state_q == ST_HUNT) ||
                   (state_q == ST_RECV);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    tmr_load  = 1'b0;
    tmr_val   = CW'(CONFIRM_CLKS);
    dec_clear = 1'b0;
    dec_step  = 1'b0;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    eop_d     = 1'b0;
    len_d     = len_q;
    ovf_d     = 1'b0;
    nos_d     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (buf_ready && ln_j) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!buf_ready) begin
          state_d = ST_IDLE;
        end else if (ln_k) begin
          state_d  = ST_CONFIRM;
          tmr_load = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (tick) begin
          if (ln_k) begin
            state_d   = ST_RECV;
            dec_clear = 1'b1;
            cnt_d     = '0;
          end else begin
            state_d  = ST_HUNT;
            tmr_load = 1'b1;
            tmr_val  = CW'(SYNC_WINDOW);
          end
        end
      end
      ST_HUNT: begin
        if (ln_k) begin
          state_d  = ST_CONFIRM;
          tmr_load = 1'b1;
        end else if (tick) begin
          state_d = ST_IDLE;
          nos_d   = 1'b1;
        end
      end
      ST_RECV: begin
        if (tick) begin
          if (ln_se0) begin
            state_d = ST_IDLE;
            eop_d   = 1'b1;
            len_d   = cnt_q;
          end else begin
            dec_step = 1'b1;
            if (byte_done) begin
              if (cnt_q == LW'(BUF_BYTES)) begin
                state_d = ST_DRAIN;
                ovf_d   = 1'b1;
              end else begin
                wr_en_d   = 1'b1;
                wr_addr_d = cnt_q[AW-1:0];
                wr_data_d = byte_val;
                cnt_d     = cnt_q + LW'(1);
              end
            end
          end
        end
      end
      ST_DRAIN: begin
        if (ln_se0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      eop_q     <= 1'b0;
      len_q     <= '0;
      ovf_q     <= 1'b0;
      nos_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      eop_q     <= eop_d;
      len_q     <= len_d;
      ovf_q     <= ovf_d;
      nos_q     <= nos_d;
    end
  end

  assign wr_en        = wr_en_q;
  assign wr_addr      = wr_addr_q;
  assign wr_data      = wr_data_q;
  assign eop_valid    = eop_q;
  assign eop_len      = len_q;
  assign err_overflow = ovf_q;
  assign err_nosync   = nos_q;

endmodule

// File: rtl/lsusb_rx_chk.sv
module lsusb_rx_chk #(
  parameter int BUF_BYTES = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           eop_valid,
  input logic [$clog2(BUF_BYTES+1)-1:0] eop_len,
  input logic                           err_overflow,
  input logic                           err_nosync
);

  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r6_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
    eop_valid |=> !eop_valid);

  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eop_valid |-> (int'(eop_len) <= BUF_BYTES));

  a_r7_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> !err_overflow);

  a_r8_nosync_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_nosync |=> !err_nosync);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, eop_valid, err_overflow, err_nosync}));

endmodule

bind lsusb_rx lsusb_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .eop_valid   (eop_valid),
  .eop_len     (eop_len),
  .err_overflow(err_overflow),
  .err_nosync  (err_nosync)
);

// File: tb/lsusb_rx_test.sv
`timescale 1ns/1ps
module lsusb_rx_test;

  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dp_in, dm_in, buf_ready;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       eop_valid;
  logic [3:0] eop_len;
  logic       err_overflow, err_nosync;

  always #2.5 clk = ~clk;

  lsusb_rx #(.BUF_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
    .buf_ready(buf_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eop_valid(eop_valid), .eop_len(eop_len),
    .err_overflow(err_overflow), .err_nosync(err_nosync)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // output monitor (counters only grow)
  int         wr_cnt = 0, eop_cnt = 0, ovf_cnt = 0, nos_cnt = 0, clash_cnt = 0;
  int         last_len = -1;
  logic [7:0] cap_data [0:63];
  int         cap_addr [0:63];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        cap_data[wr_cnt % 64] = wr_data;
        cap_addr[wr_cnt % 64] = int'(wr_addr);
        wr_cnt++;
      end
      if (eop_valid) begin
        eop_cnt++;
        last_len = int'(eop_len);
      end
      if (err_overflow) ovf_cnt++;
      if (err_nosync) nos_cnt++;
      if (int'(wr_en) + int'(eop_valid) + int'(err_overflow) + int'(err_nosync) > 1)
        clash_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // host line model
  logic [7:0] pkt [0:15];
  logic [1:0] sym [0:255];
  int         nsym;

  task automatic push(input logic [1:0] s);
    sym[nsym] = s;
    nsym++;
  endtask

  task automatic play();
    for (int i = 0; i < nsym; i++) begin
      {dp_in, dm_in} = sym[i];
      repeat (((i + 1) * 32) / 3 - (i * 32) / 3) @(negedge clk);
    end
    {dp_in, dm_in} = 2'b01;
  endtask

  // good_sync=0 makes the last sync bit J
  task automatic send(input int n, input bit good_sync, input bit with_eop);
    logic lvl;
    int   ones;
    lvl  = 1'b1;
    ones = 0;
    nsym = 0;
    for (int i = 0; i < 8; i++) begin
      if (!(good_sync && i == 7)) lvl = ~lvl;
      push(lvl ? 2'b01 : 2'b10);
    end
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) begin
        if (!pkt[k][j]) begin lvl = ~lvl; ones = 0; end
        else ones++;
        push(lvl ? 2'b01 : 2'b10);
        if (ones == 6) begin
          lvl = ~lvl;
          ones = 0;
          push(lvl ? 2'b01 : 2'b10);
        end
      end
    end
    if (with_eop) begin
      push(2'b00);
      push(2'b00);
      push(2'b01);
    end
    play();
    repeat (60) @(negedge clk);
  endtask

  task automatic expect_packet(input string req, input int n);
    int w0, e0;
    w0 = wr_cnt;
    e0 = eop_cnt;
    send(n, 1'b1, 1'b1);
    check({req, " byte count"}, wr_cnt - w0, n);
    for (int i = 0; i < n; i++) begin
      check({req, " data"}, int'(cap_data[(w0 + i) % 64]), int'(pkt[i]));
      check("R3 address", cap_addr[(w0 + i) % 64], i);
    end
    check("R6 eop count", eop_cnt - e0, 1);
    check("R6 eop_len", last_len, n);
  endtask

  task automatic t_reset();
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 eop_valid", int'(eop_valid), 0);
    check("R1 err_overflow", int'(err_overflow), 0);
    check("R1 err_nosync", int'(err_nosync), 0);
  endtask

  task automatic t_basic();
    pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h01;
    expect_packet("R3 nrzi", 3);
  endtask

  task automatic t_stuff();
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3F;
    expect_packet("R4 unstuff", 4);
  endtask

  task automatic t_full();
    pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'h55; pkt[3] = 8'hAA;
    pkt[4] = 8'h80; pkt[5] = 8'h01; pkt[6] = 8'hF0; pkt[7] = 8'h0F;
    expect_packet("R5 full-length timing", NB);
  endtask

  task automatic t_zero();
    int w0;
    w0 = wr_cnt;
    expect_packet("R6 zero length", 0);
    check("R6 zero length no write", wr_cnt - w0, 0);
  endtask

  task automatic t_overflow();
    int w0, e0, o0;
    for (int i = 0; i < 9; i++) pkt[i] = 8'(8'h11 * i);
    w0 = wr_cnt; e0 = eop_cnt; o0 = ovf_cnt;
    send(9, 1'b1, 1'b1);
    check("R7 writes before overflow", wr_cnt - w0, NB);
    check("R7 overflow pulse", ovf_cnt - o0, 1);
    check("R7 no eop", eop_cnt - e0, 0);
    pkt[0] = 8'hC3; pkt[1] = 8'h5A;
    expect_packet("R7 recovery", 2);
  endtask

  task automatic t_badsync();
    int w0, e0, n0;
    w0 = wr_cnt; e0 = eop_cnt; n0 = nos_cnt;
    send(0, 1'b0, 1'b0);
    check("R2 bad sync no write", wr_cnt - w0, 0);
    check("R2 bad sync no eop", eop_cnt - e0, 0);
    check("R8 nosync after bad sync", nos_cnt - n0, 1);
  endtask

  task automatic t_glitch();
    int w0, n0;
    w0 = wr_cnt; n0 = nos_cnt;
    nsym = 0;
    push(2'b10);
    play();
    repeat (60) @(negedge clk);
    check("R8 glitch nosync", nos_cnt - n0, 1);
    check("R8 glitch no write", wr_cnt - w0, 0);
  endtask

  task automatic t_notready();
    int w0, e0, n0, o0;
    buf_ready = 1'b0;
    repeat (4) @(negedge clk);
    pkt[0] = 8'h42; pkt[1] = 8'h24;
    w0 = wr_cnt; e0 = eop_cnt; n0 = nos_cnt; o0 = ovf_cnt;
    send(2, 1'b1, 1'b1);
    check("R9 no write", wr_cnt - w0, 0);
    check("R9 no eop", eop_cnt - e0, 0);
    check("R9 no error", (nos_cnt - n0) + (ovf_cnt - o0), 0);
    buf_ready = 1'b1;
    repeat (10) @(negedge clk);
    pkt[0] = 8'h99;
    expect_packet("R9 after ready", 1);
  endtask

  initial begin
    rst_n = 1'b0;
    {dp_in, dm_in} = 2'b01;
    buf_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_basic();
    t_stuff();
    t_full();
    t_zero();
    t_overflow();
    t_badsync();
    t_glitch();
    t_notready();
    check("R10 exclusive pulses", clash_cnt, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule